// File: doc/BRIEF.md
# NOR Flash Erase and Program Sequencer

This block sits between a host and a byte-wide parallel NOR flash that takes a command-byte protocol. The host asks for one of two jobs: erasing the sector that holds an address, or programming one byte at an address. The sequencer writes the needed command bytes on a simple synchronous flash bus. It then polls the device status byte until the ready bit comes up or a cycle-count budget runs out. It finishes every job by returning the device to read-array mode and reporting a two-bit result code.

Only one job runs at a time. The sequencer holds a busy flag for the whole job and raises a one-cycle done pulse together with the result. An erase of a sector the host marks as protected is dropped at once. A program request first reads the target cell, and is refused when the new data would need a 0-to-1 bit change. After the erase confirm byte, a minimum settle time passes before the first status read. An erase that runs out of time is suspended before read mode is restored.

Top module: `nor_seq`

## Requirements
- R1: An accepted erase of an unprotected sector makes exactly three flash writes on consecutive cycles, 0x50 then 0x20 then 0xD0, all to the sector base address (the request address with its low SECT_BITS bits cleared).
- R2: An accepted program whose precheck passes writes 0x40 and then the data byte on consecutive cycles, both to the request address, and leaves the cell holding the data.
- R3: The job completes when a status read returns bit 7 set. The sequencer then writes 0xFF and reports result 0.
- R4: After the 0xD0 erase confirm write, no flash read occurs for at least ERASE_SETTLE clock cycles.
- R5: An erase that does not see ready within ERASE_TOUT cycles of polling writes 0xB0, then 0xFF, and reports result 1.
- R6: A program first reads the target cell once. If (cell AND data) differs from data, it reports result 2 and makes no flash write.
- R7: A program that does not see ready within PROG_TOUT cycles of polling writes 0xFF and reports result 1.
- R8: An erase request with the protect flag set reports result 3 and makes no flash read or write.
- R9: busy is high from the cycle after a request is accepted until the done cycle, and a request presented while busy is high is ignored.
- R10: done is a single-cycle pulse that carries result: 0 = success, 1 = timeout, 2 = not erased, 3 = skipped.
- R11: While reset is applied, and whenever busy is low, busy, done, flWe and flRe are low.
- R12: flWe and flRe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqOp | input | 1 | 0 = erase sector, 1 = program byte |
| reqAddr | input | AW | Target address |
| reqData | input | 8 | Byte to program |
| reqProt | input | 1 | Sector is protected (erase is skipped) |
| busy | output | 1 | Job in flight |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Result code, valid with done |
| flAddr | output | AW | Flash address |
| flWdata | output | 8 | Flash write data / command byte |
| flRdata | input | 8 | Flash read data, valid the cycle after flRe |
| flWe | output | 1 | Flash write strobe |
| flRe | output | 1 | Flash read strobe |

## Verification
A bad state register or a stuck timer shows up on the flash bus within a few cycles. The bus then carries a wrong byte, a missing byte or an extra command, or a status read comes early after the erase confirm, and the bench compares every write of each job with its expected list. A wrong result path shows at the next done pulse, where the scoreboard compares the code. A bad accept or busy path shows as an extra done, or as a busy flag still low one cycle after the request.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_ESETUP  = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_READARR = 8'hFF;

  localparam logic [1:0] RES_OK    = 2'd0;
  localparam logic [1:0] RES_TOUT  = 2'd1;
  localparam logic [1:0] RES_DIRTY = 2'd2;
  localparam logic [1:0] RES_SKIP  = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_SKIP, S_ECLR, S_ESETUP, S_ECONF, S_SETTLE,
    S_POLLRD, S_POLLCHK, S_SUSP, S_RESTORE,
    S_PRERD, S_PRECHK, S_PCMD, S_PDATA
  } seqState_t;

  typedef struct packed {
    logic       we;
    logic       re;
    logic       selData;
    logic [7:0] cmd;
    logic       loadSettle;
    logic       loadErase;
    logic       loadProg;
    logic       tick;
    logic       finish;
    logic [1:0] res;
  } seqStrobe_t;

endpackage

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqOp,
  input  logic       reqProt,
  input  logic       doneBusy,
  input  logic       ready,
  input  logic       notErased,
  input  logic       timerZero,
  output logic       accept,
  output logic       active,
  output seqStrobe_t st
);

  seqState_t state, nextState;
  logic opProgQ;
  logic [1:0] resQ, resN;

  assign accept = (state == S_IDLE) && reqValid && !doneBusy;
  assign active = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      opProgQ <= 1'b0;
      resQ    <= RES_OK;
    end else begin
      state <= nextState;
      resQ  <= resN;
      if (accept) opProgQ <= reqOp;
    end
  end

  always_comb begin
    st        = '0;
    nextState = state;
    resN      = resQ;
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          if (reqOp) nextState = S_PRERD;
          else       nextState = reqProt ? S_SKIP : S_ECLR;
        end
      end
      S_SKIP: begin
        st.finish = 1'b1;
        st.res    = RES_SKIP;
        nextState = S_IDLE;
      end
      S_ECLR: begin
        st.we = 1'b1; st.cmd = CMD_CLEAR;
        nextState = S_ESETUP;
      end
      S_ESETUP: begin
        st.we = 1'b1; st.cmd = CMD_ESETUP;
        nextState = S_ECONF;
      end
      S_ECONF: begin
        st.we = 1'b1; st.cmd = CMD_CONFIRM;
        st.loadSettle = 1'b1;
        nextState = S_SETTLE;
      end
      S_SETTLE: begin
        if (timerZero) begin
          st.loadErase = 1'b1;
          nextState = S_POLLRD;
        end else begin
          st.tick = 1'b1;
        end
      end
      S_POLLRD: begin
        st.re = 1'b1; st.tick = 1'b1;
        nextState = S_POLLCHK;
      end
      S_POLLCHK: begin
        st.tick = 1'b1;
        if (ready) begin
          resN = RES_OK;
          nextState = S_RESTORE;
        end else if (timerZero) begin
          resN = RES_TOUT;
          nextState = opProgQ ? S_RESTORE : S_SUSP;
        end else begin
          nextState = S_POLLRD;
        end
      end
      S_SUSP: begin
        st.we = 1'b1; st.cmd = CMD_SUSPEND;
        nextState = S_RESTORE;
      end
      S_RESTORE: begin
        st.we = 1'b1; st.cmd = CMD_READARR;
        st.finish = 1'b1;
        st.res = resQ;
        nextState = S_IDLE;
      end
      S_PRERD: begin
        st.re = 1'b1;
        nextState = S_PRECHK;
      end
      S_PRECHK: begin
        if (notErased) begin
          st.finish = 1'b1;
          st.res = RES_DIRTY;
          nextState = S_IDLE;
        end else begin
          nextState = S_PCMD;
        end
      end
      S_PCMD: begin
        st.we = 1'b1; st.cmd = CMD_PROG;
        nextState = S_PDATA;
      end
      S_PDATA: begin
        st.we = 1'b1; st.selData = 1'b1;
        st.loadProg = 1'b1;
        nextState = S_POLLRD;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int AW           = 16,
  parameter int SECT_BITS    = 8,
  parameter int ERASE_SETTLE = 125000,
  parameter int ERASE_TOUT   = 1000000,
  parameter int PROG_TOUT    = 20000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          accept,
  input  logic          active,
  input  seqStrobe_t    st,
  input  logic          reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [7:0]    reqData,
  input  logic [7:0]    flRdata,
  output logic          ready,
  output logic          notErased,
  output logic          timerZero,
  output logic          doneQ,
  output logic          busy,
  output logic [1:0]    result,
  output logic [AW-1:0] flAddr,
  output logic [7:0]    flWdata,
  output logic          flWe,
  output logic          flRe
);

  localparam int MAXCNT = (ERASE_SETTLE > ERASE_TOUT) ?
                          ((ERASE_SETTLE > PROG_TOUT) ? ERASE_SETTLE : PROG_TOUT) :
                          ((ERASE_TOUT > PROG_TOUT) ? ERASE_TOUT : PROG_TOUT);
  localparam int TW = $clog2(MAXCNT + 1) + 1;
  localparam logic [AW-1:0] SECT_MASK = ~((AW'(1) << SECT_BITS) - AW'(1));

  logic [AW-1:0] addrQ;
  logic [7:0]    dataQ;
  logic [TW-1:0] timer;
  logic [1:0]    resultQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      timer   <= '0;
      doneQ   <= 1'b0;
      resultQ <= RES_OK;
    end else begin
      if (accept) begin
        addrQ <= reqOp ? reqAddr : (reqAddr & SECT_MASK);
        dataQ <= reqData;
      end
      if (st.loadSettle)      timer <= TW'(ERASE_SETTLE);
      else if (st.loadErase)  timer <= TW'(ERASE_TOUT);
      else if (st.loadProg)   timer <= TW'(PROG_TOUT);
      else if (st.tick && timer != '0) timer <= timer - TW'(1);
      doneQ <= st.finish;
      if (st.finish) resultQ <= st.res;
    end
  end

  assign timerZero = (timer == '0);
  assign ready     = flRdata[7];
  assign notErased = ((flRdata & dataQ) != dataQ);
  assign busy      = active || doneQ;
  assign result    = resultQ;
  assign flAddr    = addrQ;
  assign flWdata   = st.selData ? dataQ : st.cmd;
  assign flWe      = st.we;
  assign flRe      = st.re;

endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_seq_pkg::*;
#(
  parameter int AW           = 16,
  parameter int SECT_BITS    = 8,
  parameter int ERASE_SETTLE = 125000,
  parameter int ERASE_TOUT   = 1000000,
  parameter int PROG_TOUT    = 20000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [7:0]    reqData,
  input  logic          reqProt,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic [AW-1:0] flAddr,
  output logic [7:0]    flWdata,
  input  logic [7:0]    flRdata,
  output logic          flWe,
  output logic          flRe
);

  seqStrobe_t st;
  logic accept, active, ready, notErased, timerZero, doneQ;

  nor_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqProt(reqProt), .doneBusy(doneQ), .ready(ready),
    .notErased(notErased), .timerZero(timerZero),
    .accept(accept), .active(active), .st(st)
  );

  nor_seq_dp #(
    .AW(AW), .SECT_BITS(SECT_BITS), .ERASE_SETTLE(ERASE_SETTLE),
    .ERASE_TOUT(ERASE_TOUT), .PROG_TOUT(PROG_TOUT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .accept(accept), .active(active), .st(st),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData), .flRdata(flRdata),
    .ready(ready), .notErased(notErased), .timerZero(timerZero),
    .doneQ(doneQ), .busy(busy), .result(result), .flAddr(flAddr),
    .flWdata(flWdata), .flWe(flWe), .flRe(flRe)
  );

  assign done = doneQ;

endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
  parameter int ERASE_SETTLE = 125000
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       busy,
  input logic       done,
  input logic [1:0] result,
  input logic       flWe,
  input logic       flRe,
  input logic [7:0] flWdata
);

  logic [31:0] sinceConf;
  logic [7:0]  lastWr;
  logic        confWrite;

  assign confWrite = flWe && (flWdata == 8'hD0) && (lastWr == 8'h20);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceConf <= 32'(ERASE_SETTLE);
      lastWr    <= 8'h00;
    end else begin
      if (flWe) lastWr <= flWdata;
      if (confWrite) sinceConf <= 32'd0;
      else if (sinceConf < 32'(ERASE_SETTLE)) sinceConf <= sinceConf + 32'd1;
    end
  end

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(flWe && flRe));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!flWe && !flRe && !done));

  assert_settle_R4: assert property (@(posedge clk) disable iff (!rstN)
    flRe |-> (sinceConf >= 32'(ERASE_SETTLE)));

  assert_restore_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && (result == 2'd0 || result == 2'd1)) |->
      ($past(flWe) && $past(flWdata) == 8'hFF));

endmodule

bind nor_seq nor_seq_chk #(.ERASE_SETTLE(ERASE_SETTLE)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .done(done),
  .result(result), .flWe(flWe), .flRe(flRe), .flWdata(flWdata)
);

// File: tb/nor_seq_test.sv
module nor_seq_test;

  localparam int AW = 16;
  localparam int SETTLE = 20;
  localparam int ETOUT = 60;
  localparam int PTOUT = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqOp = 1'b0, reqProt = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic busy, done, flWe, flRe;
  logic [1:0] result;
  logic [AW-1:0] flAddr;
  logic [7:0] flWdata;
  logic [7:0] flRdata = 8'h00;

  always #4 clk = ~clk;

  nor_seq #(.AW(AW), .SECT_BITS(8), .ERASE_SETTLE(SETTLE),
            .ERASE_TOUT(ETOUT), .PROG_TOUT(PTOUT)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqProt(reqProt),
    .busy(busy), .done(done), .result(result), .flAddr(flAddr),
    .flWdata(flWdata), .flRdata(flRdata), .flWe(flWe), .flRe(flRe)
  );

  // flash behavioural model
  logic [7:0] mem [0:255];
  logic statusMode = 1'b0, expectData = 1'b0;
  logic [7:0] lastCmd = 8'h00;
  int busyLeft = 0;
  int eraseDur = 30;
  int progDur = 10;

  always @(posedge clk) begin
    if (busyLeft > 0) busyLeft = busyLeft - 1;
    if (flRe)
      flRdata <= statusMode ? {(busyLeft == 0), 7'h00} : mem[flAddr[7:0]];
    if (flWe) begin
      if (expectData) begin
        mem[flAddr[7:0]] = mem[flAddr[7:0]] & flWdata;
        busyLeft = progDur;
        expectData = 1'b0;
        statusMode = 1'b1;
      end else begin
        case (flWdata)
          8'h40: begin expectData = 1'b1; statusMode = 1'b1; end
          8'hD0: begin
            if (lastCmd == 8'h20) begin
              for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
              busyLeft = eraseDur;
            end
            statusMode = 1'b1;
          end
          8'hFF: begin statusMode = 1'b0; busyLeft = 0; end
          8'hB0: begin statusMode = 1'b1; busyLeft = 0; end
          default: statusMode = 1'b1;
        endcase
        lastCmd = flWdata;
      end
    end
  end

  // scoreboard and bus monitor
  int checks = 0;
  int errors = 0;
  logic [1:0] expQ [$];
  logic [7:0] wrData [$];
  logic [AW-1:0] wrAddr [$];
  int readCnt = 0;
  int doneCnt = 0;
  int cyc = 0;
  int confCyc = -1;
  int firstRdAfterConf = -1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (flWe) begin
        wrData.push_back(flWdata);
        wrAddr.push_back(flAddr);
        if (flWdata == 8'hD0 && wrData.size() >= 2 && wrData[wrData.size()-2] == 8'h20)
          confCyc = cyc;
      end
      if (flRe) begin
        readCnt++;
        if (confCyc >= 0 && firstRdAfterConf < 0) firstRdAfterConf = cyc;
      end
      if (done) begin
        doneCnt++;
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected done", result, 0);
        end else begin
          logic [1:0] e;
          e = expQ.pop_front();
          check(result == e, "R10 result code", result, e);
        end
      end
    end
  end

  task automatic runOp(input logic op, input logic [AW-1:0] addr,
                       input logic [7:0] data, input logic prot,
                       input logic [1:0] expRes, input bit intrude);
    int startDone;
    wrData.delete(); wrAddr.delete();
    readCnt = 0; confCyc = -1; firstRdAfterConf = -1;
    startDone = doneCnt;
    expQ.push_back(expRes);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqData = data; reqProt = prot;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
    if (intrude) begin
      repeat (2) @(negedge clk);
      reqValid = 1'b1; reqOp = 1'b0; reqProt = 1'b1; reqAddr = 16'h0300;
      @(negedge clk);
      reqValid = 1'b0; reqProt = 1'b0;
    end
    while (doneCnt == startDone) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", done, 0);
    check(busy == 1'b0, "R11 idle after done", busy, 0);
  endtask

  task automatic checkWrites(input string tag, input int n,
                             input logic [39:0] bytes, input logic [AW-1:0] addr);
    check(wrData.size() == n, {tag, " write count"}, wrData.size(), n);
    for (int i = 0; i < n && i < wrData.size(); i++) begin
      logic [7:0] e;
      e = bytes[39 - 8*i -: 8];
      check(wrData[i] == e, {tag, " write byte"}, wrData[i], e);
      check(wrAddr[i] == addr, {tag, " write address"}, wrAddr[i], addr);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy == 1'b0 && done == 1'b0, "R11 reset busy/done", {busy, done}, 0);
    check(flWe == 1'b0 && flRe == 1'b0, "R11 reset strobes", {flWe, flRe}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 R4: erase completes
    eraseDur = 30;
    runOp(1'b0, 16'h1234, 8'h00, 1'b0, 2'd0, 1'b0);
    checkWrites("R1 R3 erase ok", 4, {8'h50, 8'h20, 8'hD0, 8'hFF, 8'h00}, 16'h1200);
    check(firstRdAfterConf - confCyc >= SETTLE, "R4 settle gap",
          firstRdAfterConf - confCyc, SETTLE);

    // R5: erase timeout
    eraseDur = 100000;
    runOp(1'b0, 16'h12F0, 8'h00, 1'b0, 2'd1, 1'b0);
    checkWrites("R5 erase timeout", 5, {8'h50, 8'h20, 8'hD0, 8'hB0, 8'hFF}, 16'h1200);

    // R2 R3: program on erased cell
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    progDur = 10;
    runOp(1'b1, 16'h0033, 8'h5A, 1'b0, 2'd0, 1'b0);
    checkWrites("R2 program ok", 3, {8'h40, 8'h5A, 8'hFF, 16'h0000}, 16'h0033);
    check(mem[8'h33] == 8'h5A, "R2 cell contents", mem[8'h33], 8'h5A);

    // R6: compatible partial cell passes precheck
    mem[8'h44] = 8'h7E;
    runOp(1'b1, 16'h0044, 8'h5A, 1'b0, 2'd0, 1'b0);
    checkWrites("R6 compatible cell", 3, {8'h40, 8'h5A, 8'hFF, 16'h0000}, 16'h0044);

    // R6: not erased
    mem[8'h55] = 8'h0F;
    runOp(1'b1, 16'h0055, 8'hF0, 1'b0, 2'd2, 1'b0);
    check(wrData.size() == 0, "R6 no writes when dirty", wrData.size(), 0);
    check(readCnt == 1, "R6 single precheck read", readCnt, 1);
    check(mem[8'h55] == 8'h0F, "R6 cell untouched", mem[8'h55], 8'h0F);

    // R7: program timeout
    mem[8'h66] = 8'hFF;
    progDur = 100000;
    runOp(1'b1, 16'h0066, 8'h3C, 1'b0, 2'd1, 1'b0);
    checkWrites("R7 program timeout", 3, {8'h40, 8'h3C, 8'hFF, 16'h0000}, 16'h0066);

    // R8: protected erase skipped
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    mem[8'h10] = 8'h00;
    runOp(1'b0, 16'h0210, 8'h00, 1'b1, 2'd3, 1'b0);
    check(wrData.size() == 0, "R8 no writes", wrData.size(), 0);
    check(readCnt == 0, "R8 no reads", readCnt, 0);
    check(mem[8'h10] == 8'h00, "R8 sector untouched", mem[8'h10], 0);

    // R9: request while busy ignored
    mem[8'h77] = 8'hFF;
    progDur = 10;
    runOp(1'b1, 16'h0077, 8'h11, 1'b0, 2'd0, 1'b1);
    checkWrites("R9 busy ignore", 3, {8'h40, 8'h11, 8'hFF, 16'h0000}, 16'h0077);
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R9 scoreboard empty", expQ.size(), 0);
    check(busy == 1'b0, "R9 no second job", busy, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule